// File: doc/BRIEF.md
# Status Register Transfer Unit

This block keeps the processor's current status word and one saved status word for each privileged mode that owns one. It serves two operations: a read that returns a whole status word, and a write that replaces a chosen field group (all fields, condition flags only, or control bits only) from a 32-bit operand. The target is either the current word or the saved word of the mode the core is running in.

Which bits a write may reach depends on privilege. User mode may change only the condition flags of the current word. A user-mode control write is silently dropped. A user-mode touch of any saved word is refused. A refused request raises a one-cycle error pulse and leaves all state alone. A separate load port lets the surrounding logic, or a test, place a value directly into a register.

Top module: `status_xfer_unit`

## Requirements
- R1: Bit layout of every status word: N=31, Z=30, C=29, V=28, I=7, F=6, mode=4..0. All other bits always read as zero.
- R2: A legal read (`req_valid=1`, `req_write=0`) returns the selected word on `rd_data` in the same cycle and changes no state. `rd_data` is zero for writes, for idle cycles and for refused requests.
- R3: In a privileged mode, a write with `req_field=00` (all) updates N, Z, C, V, I, F and mode at the next clock edge.
- R4: A write with `req_field=01` (flags) updates only N, Z, C and V, in any mode.
- R5: In a privileged mode, a write with `req_field=10` (control) updates only I, F and mode.
- R6: In user mode (`cur_mode=10000`), an all-fields write to the current word updates only N, Z, C and V. A control write has no effect and is not refused.
- R7: A saved-word access (`req_saved=1`) in a mode owning a saved word uses the same field masking on that mode's own word. Modes 10001, 10010, 10011, 10111 and 11011 each own a separate word.
- R8: A saved-word access in user mode or in a mode owning no saved word (e.g. 11111) is refused.
- R9: A write with `req_field=11` is refused.
- R10: A refused request drives `err_pulse` high for exactly the following cycle and changes no register.
- R11: After reset the current word is 0x000000D3, every saved word is zero and `err_pulse` is low.
- R12: With `ld_en=1`, `ld_data` (undefined bits cleared) is placed into the current word (`ld_saved=0`) or the current mode's saved word (`ld_saved=1`; ignored if the mode owns none). This load takes priority over a request write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_saved | input | 1 | 1 = saved word of current mode, 0 = current word |
| req_field | input | 2 | 00 all, 01 flags, 10 control, 11 reserved |
| req_data | input | 32 | Write operand |
| cur_mode | input | 5 | Mode the core is running in |
| ld_en | input | 1 | Direct load strobe |
| ld_saved | input | 1 | Load target: 1 = saved word of current mode |
| ld_data | input | 32 | Direct load value |
| rd_data | output | 32 | Read result |
| cur_word | output | 32 | Current status word |
| saved_word | output | 32 | Saved word of current mode, zero if none |
| err_pulse | output | 1 | One-cycle refused-request indication |

## Verification
On every cycle the assertions check the following: undefined bits stay zero, refused requests pulse the error flag and freeze the current word, flag writes leave the control bits alone, control writes leave the flags alone, user-mode control writes change nothing, and user-mode saved access is always refused. The exact merged values need the bench's reference model over random mixes of modes, fields and operands. So do the separation between the five saved words, and load-port priority over a same-cycle write.

// File: rtl/sx_pkg.sv
package sx_pkg;
  localparam int WORD_W    = 32;
  localparam int MODE_W    = 5;
  localparam int NUM_SAVED = 5;
  localparam int IDX_W     = $clog2(NUM_SAVED);

  localparam logic [WORD_W-1:0] DEF_MASK   = 32'hF000_00DF;
  localparam logic [WORD_W-1:0] FLAG_MASK  = 32'hF000_0000;
  localparam logic [WORD_W-1:0] CTL_MASK   = 32'h0000_00DF;
  localparam logic [WORD_W-1:0] RESET_WORD = 32'h0000_00D3;
  localparam logic [MODE_W-1:0] MODE_USER  = 5'b10000;

  typedef enum logic [1:0] {
    FLD_ALL   = 2'b00,
    FLD_FLAGS = 2'b01,
    FLD_CTL   = 2'b10,
    FLD_RSVD  = 2'b11
  } field_e;

  // Bits a write may reach, given field select and privilege
  function automatic logic [WORD_W-1:0] field_mask(logic [1:0] fld, logic user);
    logic [WORD_W-1:0] m;
    case (fld)
      FLD_ALL:   m = user ? FLAG_MASK : (FLAG_MASK | CTL_MASK);
      FLD_FLAGS: m = FLAG_MASK;
      FLD_CTL:   m = user ? '0 : CTL_MASK;
      default:   m = '0;
    endcase
    return m;
  endfunction

  function automatic logic has_bank(logic [MODE_W-1:0] mode);
    return (mode == 5'b10001) || (mode == 5'b10010) || (mode == 5'b10011) ||
           (mode == 5'b10111) || (mode == 5'b11011);
  endfunction

  function automatic logic [IDX_W-1:0] bank_of(logic [MODE_W-1:0] mode);
    logic [IDX_W-1:0] k;
    case (mode)
      5'b10001: k = IDX_W'(0);
      5'b10010: k = IDX_W'(1);
      5'b10011: k = IDX_W'(2);
      5'b10111: k = IDX_W'(3);
      default:  k = IDX_W'(4);
    endcase
    return k;
  endfunction

  function automatic logic [WORD_W-1:0] merge(logic [WORD_W-1:0] old_w,
                                              logic [WORD_W-1:0] new_w,
                                              logic [WORD_W-1:0] m);
    return (old_w & ~m) | (new_w & m & DEF_MASK);
  endfunction
endpackage

// File: rtl/sx_access_check.sv
module sx_access_check
  import sx_pkg::*;
(
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_saved,
  input  logic [1:0]        req_field,
  input  logic [MODE_W-1:0] cur_mode,
  output logic              illegal,
  output logic              wr_cur,
  output logic              wr_sav,
  output logic              rd_cur,
  output logic              rd_sav,
  output logic              bank_ok,
  output logic [IDX_W-1:0]  bank_idx,
  output logic [WORD_W-1:0] wmask
);
  logic user_mode;
  logic bad_saved;
  logic bad_field;

  always_comb begin
    user_mode = (cur_mode == MODE_USER);
    bank_ok   = has_bank(cur_mode);
    bank_idx  = bank_of(cur_mode);
    bad_saved = req_saved && (user_mode || !bank_ok);
    bad_field = req_write && (req_field == FLD_RSVD);
    illegal   = req_valid && (bad_saved || bad_field);
    wr_cur    = req_valid && req_write  && !req_saved && !illegal;
    wr_sav    = req_valid && req_write  &&  req_saved && !illegal;
    rd_cur    = req_valid && !req_write && !req_saved && !illegal;
    rd_sav    = req_valid && !req_write &&  req_saved && !illegal;
    wmask     = field_mask(req_field, user_mode);
  end
endmodule

// File: rtl/sx_saved_bank.sv
module sx_saved_bank
  import sx_pkg::*;
#(
  parameter int NUM = NUM_SAVED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_mask,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] words [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        words[g] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        words[g] <= merge(words[g], wr_data, wr_mask);
    end
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < NUM; k++)
      if (rd_idx == IDX_W'(k)) rd_word = words[k];
  end
endmodule

// File: rtl/status_xfer_unit.sv
module status_xfer_unit
  import sx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        req_saved,
  input  logic [1:0]  req_field,
  input  logic [31:0] req_data,
  input  logic [4:0]  cur_mode,
  input  logic        ld_en,
  input  logic        ld_saved,
  input  logic [31:0] ld_data,
  output logic [31:0] rd_data,
  output logic [31:0] cur_word,
  output logic [31:0] saved_word,
  output logic        err_pulse
);
  logic              illegal_w, wr_cur_w, wr_sav_w, rd_cur_w, rd_sav_w, bank_ok_w;
  logic [IDX_W-1:0]  bank_idx_w;
  logic [WORD_W-1:0] wmask_w;
  logic [WORD_W-1:0] cur_q, bank_rd_w;
  logic              err_q;
  logic              sav_we_w;
  logic [WORD_W-1:0] sav_mask_w, sav_data_w;
  logic              ld_cur_w, ld_sav_w;

  sx_access_check u_chk (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_saved (req_saved),
    .req_field (req_field),
    .cur_mode  (cur_mode),
    .illegal   (illegal_w),
    .wr_cur    (wr_cur_w),
    .wr_sav    (wr_sav_w),
    .rd_cur    (rd_cur_w),
    .rd_sav    (rd_sav_w),
    .bank_ok   (bank_ok_w),
    .bank_idx  (bank_idx_w),
    .wmask     (wmask_w)
  );

  // Load port wins over a request write in the same cycle
  always_comb begin
    ld_cur_w   = ld_en && !ld_saved;
    ld_sav_w   = ld_en &&  ld_saved && bank_ok_w;
    sav_we_w   = ld_sav_w || (wr_sav_w && !(ld_en && ld_saved));
    sav_mask_w = ld_sav_w ? DEF_MASK : wmask_w;
    sav_data_w = ld_sav_w ? ld_data  : req_data;
  end

  sx_saved_bank #(.NUM(NUM_SAVED)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (sav_we_w),
    .wr_idx  (bank_idx_w),
    .wr_mask (sav_mask_w),
    .wr_data (sav_data_w),
    .rd_idx  (bank_idx_w),
    .rd_word (bank_rd_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cur_q <= RESET_WORD;
    else if (ld_cur_w)
      cur_q <= ld_data & DEF_MASK;
    else if (wr_cur_w)
      cur_q <= merge(cur_q, req_data, wmask_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= illegal_w;
  end

  always_comb begin
    saved_word = bank_ok_w ? bank_rd_w : '0;
    rd_data    = rd_cur_w ? cur_q : (rd_sav_w ? saved_word : '0);
  end

  assign cur_word  = cur_q;
  assign err_pulse = err_q;
endmodule

// File: rtl/sx_checker.sv
module sx_checker
  import sx_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic        req_saved,
  input logic [1:0]  req_field,
  input logic [4:0]  cur_mode,
  input logic        ld_en,
  input logic [31:0] rd_data,
  input logic [31:0] cur_word,
  input logic [31:0] saved_word,
  input logic        err_pulse,
  input logic        illegal_w
);
  logic user_m;
  assign user_m = (cur_mode == MODE_USER);

  p_undef_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_word & ~DEF_MASK) == 0) && ((saved_word & ~DEF_MASK) == 0) &&
    ((rd_data & ~DEF_MASK) == 0));

  p_flags_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_saved && req_field == FLD_FLAGS && !ld_en)
    |=> $stable(cur_word[7:0]));

  p_ctl_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_saved && req_field == FLD_CTL && !ld_en)
    |=> $stable(cur_word[31:28]));

  p_user_ctl_noeffect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_saved && user_m && req_field == FLD_CTL && !ld_en)
    |=> ($stable(cur_word) && !err_pulse));

  p_user_saved_refused_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_saved && user_m) |-> illegal_w);

  p_err_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_w |=> err_pulse);

  p_err_only_after_refusal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !illegal_w |=> !err_pulse);

  p_refused_keeps_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_w && !ld_en) |=> $stable(cur_word));
endmodule

bind status_xfer_unit sx_checker u_sx_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_saved  (req_saved),
  .req_field  (req_field),
  .cur_mode   (cur_mode),
  .ld_en      (ld_en),
  .rd_data    (rd_data),
  .cur_word   (cur_word),
  .saved_word (saved_word),
  .err_pulse  (err_pulse),
  .illegal_w  (illegal_w)
);

// File: tb/status_xfer_unit_tb_top.sv
module status_xfer_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_saved = 1'b0;
  logic [1:0]  req_field = 2'b00;
  logic [31:0] req_data = '0;
  logic [4:0]  cur_mode = 5'b10011;
  logic        ld_en = 1'b0, ld_saved = 1'b0;
  logic [31:0] ld_data = '0;
  logic [31:0] rd_data, cur_word, saved_word;
  logic        err_pulse;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_cur;
  logic [31:0] m_sav [5];
  logic        m_err;

  always #2 clk = ~clk;

  status_xfer_unit dut_i (.*);

  // Bench model restated from the requirements
  function automatic int slot(logic [4:0] m);
    case (m)
      5'b10001: return 0;
      5'b10010: return 1;
      5'b10011: return 2;
      5'b10111: return 3;
      5'b11011: return 4;
      default:  return -1;
    endcase
  endfunction

  function automatic logic [31:0] reach(logic [1:0] f, logic [4:0] m);
    logic u;
    u = (m == 5'b10000);
    if (f == 2'b01) return 32'hF000_0000;
    if (f == 2'b00) return u ? 32'hF000_0000 : 32'hF000_00DF;
    if (f == 2'b10) return u ? 32'h0 : 32'h0000_00DF;
    return 32'h0;
  endfunction

  function automatic logic refused(logic w, logic s, logic [1:0] f, logic [4:0] m);
    if (s && (m == 5'b10000 || slot(m) < 0)) return 1'b1;
    if (w && f == 2'b11) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_saved_of(logic [4:0] m);
    int k;
    k = slot(m);
    return (k < 0) ? 32'h0 : m_sav[k];
  endfunction

  // Called at a negedge; returns at the next negedge after checking.
  task automatic op(string req, logic w, logic s, logic [1:0] f, logic [31:0] d,
                    logic [4:0] m, logic le = 1'b0, logic ls = 1'b0,
                    logic [31:0] ld = 32'h0);
    logic bad;
    logic [31:0] exp_rd;
    int k;
    req_valid = 1'b1; req_write = w; req_saved = s; req_field = f;
    req_data = d; cur_mode = m; ld_en = le; ld_saved = ls; ld_data = ld;
    #1;
    bad = refused(w, s, f, m);
    exp_rd = (w || bad) ? 32'h0 : (s ? m_saved_of(m) : m_cur);
    chk({req, " rd_data"}, rd_data, exp_rd);
    @(posedge clk);
    k = slot(m);
    if (le && !ls) m_cur = ld & 32'hF000_00DF;
    else if (w && !s && !bad) m_cur = (m_cur & ~reach(f, m)) | (d & reach(f, m));
    if (le && ls && k >= 0) m_sav[k] = ld & 32'hF000_00DF;
    else if (w && s && !bad) m_sav[k] = (m_sav[k] & ~reach(f, m)) | (d & reach(f, m));
    m_err = bad;
    @(negedge clk);
    chk({req, " err_pulse"}, {31'h0, err_pulse}, {31'h0, m_err});
    chk({req, " cur_word"}, cur_word, m_cur);
    chk({req, " saved_word"}, saved_word, m_saved_of(m));
    req_valid = 1'b0; ld_en = 1'b0;
  endtask

  localparam logic [4:0] MODES [7] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                       5'b10111, 5'b11011, 5'b11111};

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_cur = 32'h0000_00D3;
    for (int i = 0; i < 5; i++) m_sav[i] = '0;
    m_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 cur_word", cur_word, 32'h0000_00D3);
    chk("R11 saved_word", saved_word, 32'h0);
    chk("R11 err_pulse", {31'h0, err_pulse}, 32'h0);
    // R2 read of current word
    op("R2 read cur", 1'b0, 1'b0, 2'b00, 32'h0, 5'b10011);
    // R3 privileged full write, R1 undefined bits dropped
    op("R3 R1 all write", 1'b1, 1'b0, 2'b00, 32'hFFFF_FFFF, 5'b10011);
    chk("R1 layout", cur_word, 32'hF000_00DF);
    // R4 flags only
    op("R4 flags write", 1'b1, 1'b0, 2'b01, 32'h5000_0000, 5'b10011);
    chk("R4 flags value", cur_word, 32'h5000_00DF);
    // R5 control only
    op("R5 ctl write", 1'b1, 1'b0, 2'b10, 32'hA000_0012, 5'b10011);
    chk("R5 ctl value", cur_word, 32'h5000_0012);
    // R6 user mode
    op("R6 user all", 1'b1, 1'b0, 2'b00, 32'hA000_00C1, 5'b10000);
    chk("R6 user all value", cur_word, 32'hA000_0012);
    op("R6 user ctl", 1'b1, 1'b0, 2'b10, 32'h0000_00DF, 5'b10000);
    chk("R6 user ctl value", cur_word, 32'hA000_0012);
    // R7 saved per mode
    op("R7 sav irq", 1'b1, 1'b1, 2'b00, 32'h3000_0092, 5'b10010);
    op("R7 sav fiq", 1'b1, 1'b1, 2'b10, 32'hF000_0051, 5'b10001);
    chk("R7 separate", saved_word, 32'h0000_0051);
    op("R7 read irq", 1'b0, 1'b1, 2'b00, 32'h0, 5'b10010);
    chk("R7 irq kept", saved_word, 32'h3000_0092);
    // R8 refused saved access
    op("R8 user saved read", 1'b0, 1'b1, 2'b00, 32'h0, 5'b10000);
    op("R8 system saved write", 1'b1, 1'b1, 2'b00, 32'hFFFF_FFFF, 5'b11111);
    // R9 reserved field
    op("R9 rsvd field", 1'b1, 1'b0, 2'b11, 32'hFFFF_FFFF, 5'b10011);
    // R10 pulse is single cycle
    @(negedge clk);
    chk("R10 pulse width", {31'h0, err_pulse}, 32'h0);
    // R12 load priority
    op("R12 load cur", 1'b1, 1'b0, 2'b00, 32'h0, 5'b10011, 1'b1, 1'b0, 32'hFFFF_FF1F);
    chk("R12 load value", cur_word, 32'hF000_001F);
    op("R12 load sav", 1'b1, 1'b1, 2'b00, 32'h0, 5'b10111, 1'b1, 1'b1, 32'h8000_0017);
    chk("R12 load sav value", saved_word, 32'h8000_0017);
    // Random mix
    for (int n = 0; n < 600; n++) begin
      logic [4:0] mm;
      logic le;
      mm = MODES[$urandom_range(0, 6)];
      le = ($urandom_range(0, 15) == 0);
      op("R3 R4 R5 R6 R7 R8 R9 R12 random", 1'($urandom), 1'($urandom),
         2'($urandom), $urandom, mm, le, 1'($urandom), $urandom);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule